// File: doc/BRIEF.md
# Scaled Pack and Saturate Unit

This block narrows packed signed fixed-point lanes into smaller pixel bytes or 16-bit fixed-point values. Each source lane is sign-extended to 64 bits and shifted left by a scale factor taken from a field of a 64-bit status word. It is then shifted right arithmetically by a fixed amount that depends on the mode. The result is clamped to the range of the destination lane and placed at its lane position in the result.

Three modes are supported. The first packs four 16-bit lanes into four bytes. The second packs two 32-bit lanes into bytes and merges them into a copy of the first operand moved up by one byte, so that a pixel stream can be built one byte per lane over successive operations. The third packs two 32-bit lanes into two signed 16-bit values. A request is accepted when `in_valid` is high. The result and `out_valid` appear on the next clock edge, and the result is held until the next request.

Top module: `fxpack_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. A synchronous active-low reset clears `out_valid` and `result` to zero.
- R2: `mode_sel` encodes 2'b00 as 16-to-8 pack, 2'b01 as 32-to-8 merge pack and 2'b10 as 32-to-16 fixed pack. 2'b11 produces an all-zero result.
- R3: In 16-to-8 mode the scale is `gsr[6:3]`. Lane k is the signed `opb[16k+15:16k]`, shifted left by the scale and then arithmetically right by 7. The clamped lane goes to `result[8k+7:8k]`, and `result[63:32]` is zero.
- R4: The 16-to-8 clamp maps any negative value to 0 and any value above 255 to 255. Values from 0 to 255 pass through unchanged.
- R5: In 32-to-8 mode the scale is `gsr[7:3]`. The signed lanes are `opb[31:0]` and `opb[63:32]`. Each lane is shifted left by the scale and arithmetically right by 23, then clamped to 0..255. Lane 0 goes to `result[7:0]` and lane 1 to `result[39:32]`.
- R6: In 32-to-8 mode `result[31:8]` equals `opa[23:0]` and `result[63:40]` equals `opa[55:32]`.
- R7: In fixed mode the scale is `gsr[7:3]`. Each signed 32-bit lane of `opb` is shifted left by the scale and arithmetically right by 16, then clamped to -32768..32767. Lane 0 goes to `result[15:0]` and lane 1 to `result[31:16]`. `result[63:32]` is zero.
- R8: Scaling is exact at 64 bits. A scale of up to 31 on a 32-bit lane never wraps the sign before the clamp; for example, +1 scaled by 31 in fixed mode clamps to 32767.
- R9: Status bits outside the scale field of the current mode have no effect. In 16-to-8 mode this includes `gsr[7]`.
- R10: While `in_valid` is low, `result` holds its last value and input changes are not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode_sel | input | 2 | Pack mode select |
| gsr | input | 64 | Status word holding the scale field |
| opa | input | 64 | Merge operand (32-to-8 mode) |
| opb | input | 64 | Packed source lanes |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 64 | Packed result |

## Verification
The bench sweeps every scale value in every mode and drives lane values one step below, at and above each clamp limit. A design with an off-by-one limit or a wrong shift count would miscompare there. Negative lanes and the most negative 32-bit value are included: a logical right shift in place of an arithmetic one would give large positive results instead of 0 or -32768. Scale 31 on small and negative lanes targets a 32-bit datapath, which would wrap the sign. Status words with every non-scale bit set, including bit 7 in 16-to-8 mode, expose a scale field that is too wide or misplaced.

// File: rtl/fxpack_pkg.sv
package fxpack_pkg;

  localparam int ACC_W       = 64;
  localparam int SCALE_MAX_W = 6;

  typedef enum logic [1:0] {
    PK_BYTE16 = 2'b00,
    PK_BYTE32 = 2'b01,
    PK_FIX16  = 2'b10,
    PK_RSVD   = 2'b11
  } pk_mode_e;

  // Up-scale by a variable amount, then arithmetic down-shift by a constant.
  function automatic logic signed [ACC_W-1:0] fx_scale_rsh(
    input logic signed [ACC_W-1:0]   x,
    input logic [SCALE_MAX_W-1:0]    sc,
    input int unsigned               rsh
  );
    logic signed [ACC_W-1:0] up;
    up = x <<< sc;
    return up >>> rsh;
  endfunction

  // Clamp a wide signed value into [lo, hi].
  function automatic logic signed [ACC_W-1:0] fx_clamp(
    input logic signed [ACC_W-1:0] v,
    input logic signed [ACC_W-1:0] lo,
    input logic signed [ACC_W-1:0] hi
  );
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

endpackage

// File: rtl/fxpack_lane.sv
module fxpack_lane
  import fxpack_pkg::*;
#(
  parameter int IN_W       = 16,
  parameter int OUT_W      = 8,
  parameter int SC_W       = 4,
  parameter int RSH        = 7,
  parameter bit SIGNED_OUT = 1'b0
) (
  input  logic [IN_W-1:0]  src,
  input  logic [SC_W-1:0]  scale,
  output logic [OUT_W-1:0] q,
  output logic             sat_hi,
  output logic             sat_lo
);

  localparam logic signed [ACC_W-1:0] ONE    = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] HI_LIM = SIGNED_OUT ? ((ONE <<< (OUT_W-1)) - ONE)
                                                          : ((ONE <<< OUT_W) - ONE);
  localparam logic signed [ACC_W-1:0] LO_LIM = SIGNED_OUT ? ~HI_LIM : '0;

  logic signed [ACC_W-1:0] wide;
  logic signed [ACC_W-1:0] shifted;
  logic signed [ACC_W-1:0] clipped;

  always_comb begin
    wide    = {{(ACC_W-IN_W){src[IN_W-1]}}, src};
    shifted = fx_scale_rsh(wide, SCALE_MAX_W'(scale), RSH);
    clipped = fx_clamp(shifted, LO_LIM, HI_LIM);
    sat_hi  = (shifted > HI_LIM);
    sat_lo  = (shifted < LO_LIM);
    q       = clipped[OUT_W-1:0];
  end

endmodule

// File: rtl/fxpack_merge.sv
module fxpack_merge #(
  parameter int WORD_W = 64,
  parameter int HALF_W = 32,
  parameter int GAP_W  = 8
) (
  input  logic [WORD_W-1:0] opa,
  output logic [WORD_W-1:0] base
);

  localparam int N_HALF = WORD_W / HALF_W;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign base[h*HALF_W +: HALF_W] = {opa[h*HALF_W +: (HALF_W-GAP_W)], {GAP_W{1'b0}}};
  end

endmodule

// File: rtl/fxpack_unit.sv
module fxpack_unit
  import fxpack_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int SC_LSB   = 3,
  parameter int SC16_W   = 4,
  parameter int SC32_W   = 5,
  parameter int RSH_B16  = 7,
  parameter int RSH_B32  = 23,
  parameter int RSH_FIX  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode_sel,
  input  logic [WORD_W-1:0] gsr,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);

  localparam int W16 = 16;
  localparam int W32 = 32;
  localparam int W8  = 8;
  localparam int N16 = WORD_W / W16;
  localparam int N32 = WORD_W / W32;

  logic [SC16_W-1:0] scale16;
  logic [SC32_W-1:0] scale32;
  assign scale16 = gsr[SC_LSB +: SC16_W];
  assign scale32 = gsr[SC_LSB +: SC32_W];

  // Lane results and saturation events, brought out for the checker.
  logic [W8-1:0]  q16  [N16];
  logic [W8-1:0]  q32b [N32];
  logic [W16-1:0] qfx  [N32];
  logic [N16-1:0] sat16_hi, sat16_lo;
  logic [N32-1:0] sat32_hi, sat32_lo;
  logic [N32-1:0] satfx_hi, satfx_lo;
  logic [WORD_W-1:0] merge_base;

  for (genvar k = 0; k < N16; k++) begin : g_b16
    fxpack_lane #(
      .IN_W(W16), .OUT_W(W8), .SC_W(SC16_W), .RSH(RSH_B16), .SIGNED_OUT(1'b0)
    ) u_lane (
      .src(opb[k*W16 +: W16]), .scale(scale16), .q(q16[k]),
      .sat_hi(sat16_hi[k]), .sat_lo(sat16_lo[k])
    );
  end

  for (genvar w = 0; w < N32; w++) begin : g_w32
    fxpack_lane #(
      .IN_W(W32), .OUT_W(W8), .SC_W(SC32_W), .RSH(RSH_B32), .SIGNED_OUT(1'b0)
    ) u_byte (
      .src(opb[w*W32 +: W32]), .scale(scale32), .q(q32b[w]),
      .sat_hi(sat32_hi[w]), .sat_lo(sat32_lo[w])
    );
    fxpack_lane #(
      .IN_W(W32), .OUT_W(W16), .SC_W(SC32_W), .RSH(RSH_FIX), .SIGNED_OUT(1'b1)
    ) u_fix (
      .src(opb[w*W32 +: W32]), .scale(scale32), .q(qfx[w]),
      .sat_hi(satfx_hi[w]), .sat_lo(satfx_lo[w])
    );
  end

  fxpack_merge #(.WORD_W(WORD_W), .HALF_W(W32), .GAP_W(W8)) u_merge (
    .opa(opa), .base(merge_base)
  );

  logic [WORD_W-1:0] res_c;
  always_comb begin
    res_c = '0;
    unique case (pk_mode_e'(mode_sel))
      PK_BYTE16: for (int k = 0; k < N16; k++) res_c[k*W8 +: W8] = q16[k];
      PK_BYTE32: begin
        res_c = merge_base;
        for (int w = 0; w < N32; w++) res_c[w*W32 +: W8] = res_c[w*W32 +: W8] | q32b[w];
      end
      PK_FIX16:  for (int w = 0; w < N32; w++) res_c[w*W16 +: W16] = qfx[w];
      default:   res_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_c;
    end
  end

endmodule

// File: rtl/fxpack_chk.sv
module fxpack_chk #(
  parameter int WORD_W = 64,
  parameter int N16    = 4,
  parameter int N32    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        mode_sel,
  input logic [WORD_W-1:0] opa,
  input logic [WORD_W-1:0] opb,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic [N16-1:0]    sat16_hi,
  input logic [N32-1:0]    satfx_hi,
  input logic [N32-1:0]    satfx_lo
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b11) |=> (result == '0));

  assert_b16_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b00) |=> (result[63:32] == 32'h0));

  assert_b16_neg_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b00 && opb[15]) |=> (result[7:0] == 8'h00));

  assert_b16_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b00 && sat16_hi[0]) |=> (result[7:0] == 8'hFF));

  assert_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b01) |=>
      (result[31:8] == $past(opa[23:0]) && result[63:40] == $past(opa[55:32])));

  assert_fix_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b10) |=> (result[63:32] == 32'h0));

  assert_fix_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b10 && opb[31]) |=> result[15]);

  assert_fix_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({satfx_hi[0], satfx_lo[0]}));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

endmodule

bind fxpack_unit fxpack_chk #(.WORD_W(WORD_W), .N16(N16), .N32(N32)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
  .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
  .sat16_hi(sat16_hi), .satfx_hi(satfx_hi), .satfx_lo(satfx_lo)
);

// File: tb/fxpack_unit_tb.sv
`timescale 1ns/1ps
module fxpack_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [63:0] gsr = '0, opa = '0, opb = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [63:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;

  fxpack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
    .gsr(gsr), .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
  );

  // Independent model: multiply by 2^s and floor-divide by 2^r.
  function automatic longint floor_div(longint p, longint d);
    if (p >= 0) return p / d;
    return -((-p + d - 1) / d);
  endfunction

  function automatic longint lim(longint v, longint lo, longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic logic [63:0] model(logic [1:0] m, logic [63:0] g, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    longint x, v;
    int s;
    r = '0;
    case (m)
      2'b00: begin
        s = int'(g[6:3]);
        for (int k = 0; k < 4; k++) begin
          x = longint'($signed(b[16*k +: 16]));
          v = lim(floor_div(x * (longint'(1) << s), 128), 0, 255);
          r[8*k +: 8] = v[7:0];
        end
      end
      2'b01: begin
        s = int'(g[7:3]);
        r[31:8]  = a[23:0];
        r[63:40] = a[55:32];
        for (int w = 0; w < 2; w++) begin
          x = longint'($signed(b[32*w +: 32]));
          v = lim(floor_div(x * (longint'(1) << s), 64'sd8388608), 0, 255);
          r[32*w +: 8] = v[7:0];
        end
      end
      2'b10: begin
        s = int'(g[7:3]);
        for (int w = 0; w < 2; w++) begin
          x = longint'($signed(b[32*w +: 32]));
          v = lim(floor_div(x * (longint'(1) << s), 65536), -32768, 32767);
          r[16*w +: 16] = v[15:0];
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic apply(input logic [1:0] m, input logic [63:0] g, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    sb_item_t it;
    @(negedge clk);
    mode_sel = m; gsr = g; opa = a; opb = b; in_valid = 1'b1;
    it.exp = model(m, g, a, b);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic direct(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compare each produced result with the queued expectation.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_vec++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1: actual unexpected result %h expected none", result);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (result !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, result, it.exp);
        end
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    direct({63'b0, out_valid}, 64'h0, "R1 reset out_valid");
    direct(result, 64'h0, "R1 reset result");
    rst_n = 1'b1;

    // R3 basic 16-to-8 patterns
    apply(2'b00, 64'h0, 64'h0, 64'h0100_0080_0040_7f80, "R3");
    apply(2'b00, 64'h8, 64'h0, 64'h00ff_0040_1234_0001, "R3");
    // R4 clamp boundaries at scale 0
    apply(2'b00, 64'h0, 64'h0, {16'sd32640, 16'sd32639, 16'sd32767, 16'hffff}, "R4");
    apply(2'b00, 64'h0, 64'h0, {16'sd127, 16'sd128, 16'h8000, 16'h0000}, "R4");
    apply(2'b00, 64'h0, 64'h0, {16'h0000, 16'hff80, 16'sd32768, 16'sd255}, "R4");
    // R3 every scale
    for (int s = 0; s < 16; s++)
      apply(2'b00, 64'(s) << 3, 64'h0, 64'h0001_0003_fff0_0081, "R3 scale");

    // R5 every scale, plus limits
    for (int s = 0; s < 32; s++)
      apply(2'b01, 64'(s) << 3, 64'hA5A5_A5A5_5A5A_5A5A, 64'h0000_0100_ffff_ff00, "R5 scale");
    apply(2'b01, 64'h0, 64'h0, {32'h7F80_0000, 32'h7F7F_FFFF}, "R5");
    apply(2'b01, 64'h8, 64'h0, {32'h4000_0000, 32'h8000_0000}, "R5");
    // R6 merge patterns
    apply(2'b01, 64'h0, 64'h1122_3344_5566_7788, 64'h0, "R6");
    apply(2'b01, 64'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0080_0000_0000_0000, "R6");

    // R7 every scale, plus limits
    for (int s = 0; s < 32; s++)
      apply(2'b10, 64'(s) << 3, 64'h0, 64'h0000_1234_FFFF_8000, "R7 scale");
    apply(2'b10, 64'h0, 64'h0, {32'h7FFF_FFFF, 32'h8000_0000}, "R7");
    apply(2'b10, 64'h0, 64'h0, {32'h7FFF_0000, 32'h8000_FFFF}, "R7");
    apply(2'b10, 64'h8, 64'h0, {32'h4000_0000, 32'h3FFF_0000}, "R7");

    // R8 scale 31 must not wrap
    apply(2'b10, 64'(31) << 3, 64'h0, {32'h0000_0001, 32'hFFFF_FFFF}, "R8");
    apply(2'b01, 64'(31) << 3, 64'h0, {32'h0000_0001, 32'hFFFF_FFFF}, "R8");
    apply(2'b10, 64'(31) << 3, 64'h0, {32'h0000_0000, 32'h0000_0001}, "R8");

    // R9 non-scale status bits set
    apply(2'b00, ~64'h78, 64'h0, 64'h0001_0002_0100_0080, "R9");
    apply(2'b00, ~64'h78 | 64'h8, 64'h0, 64'h0001_0002_0100_0080, "R9");
    apply(2'b10, ~64'hF8, 64'h0, 64'h0001_0000_0002_0000, "R9");
    apply(2'b01, ~64'hF8, 64'h0, 64'h0080_0000_0100_0000, "R9");

    // R2 reserved mode
    apply(2'b11, 64'h18, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, "R2");

    // R10 hold while idle
    apply(2'b00, 64'h0, 64'h0, 64'h0040_0080_00C0_0100, "R10 load");
    held = model(2'b00, 64'h0, 64'h0, 64'h0040_0080_00C0_0100);
    @(negedge clk);
    in_valid = 1'b0; opb = 64'h7FFF_7FFF_7FFF_7FFF; mode_sel = 2'b10;
    repeat (3) @(negedge clk);
    direct(result, held, "R10 hold");
    direct({63'b0, out_valid}, 64'h0, "R10 idle out_valid");

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b1; mode_sel = 2'b00; opb = 64'h0100_0100_0100_0100;
    @(negedge clk);
    direct({63'b0, out_valid}, 64'h0, "R1 reset out_valid");
    direct(result, 64'h0, "R1 reset result");
    in_valid = 1'b0; rst_n = 1'b1;
    idle(2);

    direct(64'(sb_q.size()), 64'h0, "R1 scoreboard drained");
    done = 1'b1;
    summary();
    $finish;
  end

endmodule